// File: doc/BRIEF.md
# Memory LCD Line Update Serializer

This block drives a monochrome memory-in-pixel panel over a write-only serial link made of a serial clock, a data line and an active-high chip select. A host issues one of three commands: refresh a range of rows from a line buffer, blank the whole panel, or send a keep-alive frame that leaves the picture untouched. Each keep-alive frame carries the common-electrode polarity bit. The host toggles that bit between frames so that no DC bias builds up in the panel.

For a row refresh, the block fetches the 1-bit pixel bytes of each row from a synchronous line-buffer read port. It sends a single mode byte first. For each row it then sends the address byte, the pixel bytes and a trailing zero byte, always covering the full panel width. Every byte goes out least-significant bit first. Data changes only while the serial clock falls, so it is stable at each rising edge. Panel width, panel height, clock divider and chip-select guard times are parameters.

Top module: `mlcd_line_tx`

## Requirements
- R1: The first byte of a frame is the mode byte. Its low bits encode the command: `cmd_op` 1 (row refresh) gives 0x01, 2 (blank) gives 0x04, and 0 or 3 (keep-alive) gives 0x00. Bit 1 is ORed with the `vcom_pol` value sampled when the command is accepted.
- R2: Every byte is shifted least-significant bit first. `sdo` changes only at the falling edge of `sclk` and is steady at each rising edge. `sclk` rests low.
- R3: A blank or keep-alive frame is exactly two bytes: the mode byte, then 0x00.
- R4: After the single mode byte, a row refresh sends each row in turn as follows:
  - the address byte, equal to the row index plus one;
  - `WIDTH_PX/8` pixel bytes read from line-buffer address `row*(WIDTH_PX/8)+k`, for k rising from 0;
  - one 0x00 byte.
  The frame is 1 + (WIDTH_PX/8 + 2) × rows bytes long.
- R5: Rows are sent in ascending order from `cmd_row_first` to `cmd_row_last`, both included. If the last row is below the first, only the first row is sent. A row index above `HEIGHT-1` is clamped to `HEIGHT-1`.
- R6: The line-buffer read port returns data one cycle after `lb_rd_en`. `lb_rd_en` is only raised while `busy` is high.
- R7: `cs` stays high from acceptance until after the final bit. It rises at least `CS_SETUP` serial periods before the first rising `sclk` and falls at least `CS_HOLD` serial periods after the last falling `sclk`. `sclk` pulses only while `cs` is high.
- R8: `busy` is high from the cycle after acceptance until `cs` falls. A `cmd_valid` presented while `busy` is high is ignored and produces no frame.
- R9: `done` is a one-cycle pulse in the same cycle that `cs` falls, once per frame.
- R10: After reset, `cs`, `sclk`, `sdo`, `busy`, `done` and `lb_rd_en` are all low.
- R11: The serial clock period is `2*HALF_DIV` system clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken when not busy |
| cmd_op | input | 2 | 0 keep-alive, 1 row refresh, 2 blank, 3 keep-alive |
| cmd_row_first | input | ROW_W | First row to refresh (0-based) |
| cmd_row_last | input | ROW_W | Last row to refresh (0-based) |
| vcom_pol | input | 1 | Polarity bit placed in mode byte bit 1 |
| lb_rd_en | output | 1 | Line-buffer read strobe |
| lb_rd_addr | output | LB_AW | Line-buffer byte address |
| lb_rd_data | input | 8 | Line-buffer byte, valid one cycle after the strobe |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data |
| cs | output | 1 | Chip select, active high |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
A wrong row counter or address computation appears within one serial byte as an incorrect address byte or wrong pixel bytes, and usually as a frame of the wrong length. A shift-index or bit-order fault corrupts the very first mode byte. A sequencing fault in the end-of-frame decision shows as a missing or extra trailer. That fault also moves the `cs` fall and the `done` pulse by whole bytes. A phase fault in the timing engine shows within one serial period as `sdo` moving while `sclk` is high, or as a guard interval shorter than programmed.

// File: rtl/mlcd_pkg.sv
`timescale 1ns/1ps
package mlcd_pkg;
  typedef enum logic [1:0] {
    OP_KEEP  = 2'd0,
    OP_ROWS  = 2'd1,
    OP_BLANK = 2'd2,
    OP_ALT   = 2'd3
  } mlcd_op_e;

  typedef enum logic [2:0] {
    IT_MODE, IT_ADDR, IT_PIX, IT_TAIL, IT_PAD
  } mlcd_item_e;

  typedef enum logic [1:0] {
    PH_IDLE, PH_LEAD, PH_SHIFT, PH_TRAIL
  } mlcd_phase_e;

  function automatic logic [7:0] mode_code(input mlcd_op_e op, input logic pol);
    logic [7:0] base;
    case (op)
      OP_ROWS:  base = 8'h01;
      OP_BLANK: base = 8'h04;
      default:  base = 8'h00;
    endcase
    return base | {6'd0, pol, 1'b0};
  endfunction
endpackage

// File: rtl/mlcd_sclk_timer.sv
`timescale 1ns/1ps
module mlcd_sclk_timer #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mid_tick,
  output logic bit_tick
);
  localparam int BIT_CYC = 2 * HALF_DIV;
  localparam int CW = (BIT_CYC > 2) ? $clog2(BIT_CYC) : 1;

  logic [CW-1:0] cyc;

  always_ff @(posedge clk) begin
    if (rst || !run) cyc <= '0;
    else if (cyc == CW'(BIT_CYC - 1)) cyc <= '0;
    else cyc <= cyc + 1'b1;
  end

  assign mid_tick = run && (cyc == CW'(HALF_DIV - 1));
  assign bit_tick = run && (cyc == CW'(BIT_CYC - 1));
endmodule

// File: rtl/mlcd_bit_engine.sv
`timescale 1ns/1ps
module mlcd_bit_engine
  import mlcd_pkg::*;
#(
  parameter int CS_SETUP = 1,
  parameter int CS_HOLD  = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       mid_tick,
  input  logic       bit_tick,
  input  logic [7:0] byte_in,
  input  logic       byte_last,
  output logic       advance,
  output logic       sclk,
  output logic       sdo,
  output logic       cs,
  output logic       busy,
  output logic       done
);
  localparam int GMAX = (CS_SETUP > CS_HOLD) ? CS_SETUP : CS_HOLD;
  localparam int GW   = (GMAX > 1) ? $clog2(GMAX + 1) : 1;

  mlcd_phase_e   ph;
  logic [7:0]    shreg;
  logic [2:0]    bidx;
  logic          lastf;
  logic [GW-1:0] gcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_IDLE;
      shreg   <= '0;
      bidx    <= '0;
      lastf   <= 1'b0;
      gcnt    <= '0;
      advance <= 1'b0;
      sclk    <= 1'b0;
      sdo     <= 1'b0;
      cs      <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      advance <= 1'b0;
      done    <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (start) begin
            ph   <= PH_LEAD;
            cs   <= 1'b1;
            busy <= 1'b1;
            gcnt <= '0;
          end
        end
        PH_LEAD: begin
          if (bit_tick) begin
            if (gcnt == GW'(CS_SETUP - 1)) begin
              ph      <= PH_SHIFT;
              shreg   <= byte_in;
              lastf   <= byte_last;
              sdo     <= byte_in[0];
              bidx    <= '0;
              advance <= 1'b1;
            end else begin
              gcnt <= gcnt + 1'b1;
            end
          end
        end
        PH_SHIFT: begin
          if (mid_tick) sclk <= 1'b1;
          if (bit_tick) begin
            sclk <= 1'b0;
            if (bidx != 3'd7) begin
              bidx  <= bidx + 1'b1;
              shreg <= shreg >> 1;
              sdo   <= shreg[1];
            end else if (lastf) begin
              ph   <= PH_TRAIL;
              sdo  <= 1'b0;
              gcnt <= '0;
            end else begin
              shreg   <= byte_in;
              lastf   <= byte_last;
              sdo     <= byte_in[0];
              bidx    <= '0;
              advance <= 1'b1;
            end
          end
        end
        PH_TRAIL: begin
          if (bit_tick) begin
            if (gcnt == GW'(CS_HOLD - 1)) begin
              ph   <= PH_IDLE;
              cs   <= 1'b0;
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              gcnt <= gcnt + 1'b1;
            end
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mlcd_frame_seq.sv
`timescale 1ns/1ps
module mlcd_frame_seq
  import mlcd_pkg::*;
#(
  parameter int WIDTH_PX = 32,
  parameter int HEIGHT   = 12,
  localparam int BPR   = WIDTH_PX / 8,
  localparam int ROW_W = (HEIGHT > 1) ? $clog2(HEIGHT) : 1,
  localparam int LB_AW = (HEIGHT * BPR > 1) ? $clog2(HEIGHT * BPR) : 1,
  localparam int CLW   = (BPR > 1) ? $clog2(BPR) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  mlcd_op_e         op,
  input  logic [ROW_W-1:0] row_first,
  input  logic [ROW_W-1:0] row_last,
  input  logic             pol,
  input  logic             advance,
  input  logic [7:0]       lb_rd_data,
  output logic [7:0]       nxt_byte,
  output logic             nxt_last,
  output logic             lb_rd_en,
  output logic [LB_AW-1:0] lb_rd_addr
);
  mlcd_item_e       item;
  logic [ROW_W-1:0] row;
  logic [ROW_W-1:0] end_row;
  logic [CLW-1:0]   col;
  logic             is_rows;
  logic             rd_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      item       <= IT_MODE;
      row        <= '0;
      end_row    <= '0;
      col        <= '0;
      is_rows    <= 1'b0;
      rd_pend    <= 1'b0;
      nxt_byte   <= '0;
      nxt_last   <= 1'b0;
      lb_rd_en   <= 1'b0;
      lb_rd_addr <= '0;
    end else begin
      lb_rd_en <= 1'b0;
      rd_pend  <= lb_rd_en;
      if (rd_pend) nxt_byte <= lb_rd_data;
      if (start) begin
        item     <= IT_MODE;
        nxt_byte <= mode_code(op, pol);
        nxt_last <= 1'b0;
        row      <= row_first;
        end_row  <= (row_last < row_first) ? row_first : row_last;
        is_rows  <= (op == OP_ROWS);
      end else if (advance) begin
        case (item)
          IT_MODE: begin
            if (is_rows) begin
              item     <= IT_ADDR;
              nxt_byte <= 8'(row) + 8'd1;
            end else begin
              item     <= IT_PAD;
              nxt_byte <= 8'h00;
              nxt_last <= 1'b1;
            end
          end
          IT_ADDR: begin
            item       <= IT_PIX;
            col        <= '0;
            lb_rd_en   <= 1'b1;
            lb_rd_addr <= LB_AW'(row) * LB_AW'(BPR);
          end
          IT_PIX: begin
            if (col == CLW'(BPR - 1)) begin
              item     <= IT_TAIL;
              nxt_byte <= 8'h00;
              nxt_last <= (row == end_row);
            end else begin
              col        <= col + 1'b1;
              lb_rd_en   <= 1'b1;
              lb_rd_addr <= lb_rd_addr + 1'b1;
            end
          end
          IT_TAIL: begin
            item     <= IT_ADDR;
            row      <= row + 1'b1;
            nxt_byte <= 8'(row) + 8'd2;
            nxt_last <= 1'b0;
          end
          default: item <= IT_PAD;
        endcase
      end
    end
  end
endmodule

// File: rtl/mlcd_line_tx.sv
`timescale 1ns/1ps
module mlcd_line_tx
  import mlcd_pkg::*;
#(
  parameter int WIDTH_PX = 32,
  parameter int HEIGHT   = 12,
  parameter int HALF_DIV = 2,
  parameter int CS_SETUP = 1,
  parameter int CS_HOLD  = 1,
  localparam int BPR   = WIDTH_PX / 8,
  localparam int ROW_W = (HEIGHT > 1) ? $clog2(HEIGHT) : 1,
  localparam int LB_AW = (HEIGHT * BPR > 1) ? $clog2(HEIGHT * BPR) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [ROW_W-1:0] cmd_row_first,
  input  logic [ROW_W-1:0] cmd_row_last,
  input  logic             vcom_pol,
  output logic             lb_rd_en,
  output logic [LB_AW-1:0] lb_rd_addr,
  input  logic [7:0]       lb_rd_data,
  output logic             sclk,
  output logic             sdo,
  output logic             cs,
  output logic             busy,
  output logic             done
);
  localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(HEIGHT - 1);

  logic             accept;
  logic [ROW_W-1:0] first_cl, last_cl;
  logic             mid_tick, bit_tick, advance, nxt_last;
  logic [7:0]       nxt_byte;

  assign accept   = cmd_valid && !busy;
  assign first_cl = (cmd_row_first > ROW_MAX) ? ROW_MAX : cmd_row_first;
  assign last_cl  = (cmd_row_last  > ROW_MAX) ? ROW_MAX : cmd_row_last;

  mlcd_sclk_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk(clk), .rst(rst), .run(busy),
    .mid_tick(mid_tick), .bit_tick(bit_tick)
  );

  mlcd_frame_seq #(.WIDTH_PX(WIDTH_PX), .HEIGHT(HEIGHT)) u_seq (
    .clk(clk), .rst(rst), .start(accept), .op(mlcd_op_e'(cmd_op)),
    .row_first(first_cl), .row_last(last_cl), .pol(vcom_pol),
    .advance(advance), .lb_rd_data(lb_rd_data),
    .nxt_byte(nxt_byte), .nxt_last(nxt_last),
    .lb_rd_en(lb_rd_en), .lb_rd_addr(lb_rd_addr)
  );

  mlcd_bit_engine #(.CS_SETUP(CS_SETUP), .CS_HOLD(CS_HOLD)) u_eng (
    .clk(clk), .rst(rst), .start(accept),
    .mid_tick(mid_tick), .bit_tick(bit_tick),
    .byte_in(nxt_byte), .byte_last(nxt_last), .advance(advance),
    .sclk(sclk), .sdo(sdo), .cs(cs), .busy(busy), .done(done)
  );
endmodule

// File: rtl/mlcd_line_tx_chk.sv
`timescale 1ns/1ps
module mlcd_line_tx_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic cs,
  input logic sclk,
  input logic sdo,
  input logic lb_rd_en
);
  AST_SCLK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst) sclk |-> cs); // R7
  AST_SDO_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (rst) $rose(sclk) |-> $stable(sdo)); // R2
  AST_CS_FROM_IDLE: assert property (@(posedge clk) disable iff (rst) $rose(cs) |-> !$past(busy)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !busy |-> (!cs && !sclk)); // R8
  AST_DONE_AT_CS_FALL: assert property (@(posedge clk) disable iff (rst) done |-> $fell(cs)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R9
  AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst) lb_rd_en |-> busy); // R6
endmodule

bind mlcd_line_tx mlcd_line_tx_chk u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .cs(cs), .sclk(sclk), .sdo(sdo), .lb_rd_en(lb_rd_en)
);

// File: tb/mlcd_line_tx_test.sv
`timescale 1ns/1ps
module mlcd_line_tx_test;
  localparam int W = 32, H = 12, HD = 2, CSS = 1, CSH = 1;
  localparam int BPR = W / 8, ROW_W = $clog2(H), LB_AW = $clog2(H * BPR);
  localparam int MAXBITS = 1024;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, vcom_pol = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [ROW_W-1:0] cmd_row_first = '0, cmd_row_last = '0;
  logic lb_rd_en, sclk, sdo, cs, busy, done;
  logic [LB_AW-1:0] lb_rd_addr;
  logic [7:0] lb_rd_data = 8'h00;

  int n_chk = 0, n_fail = 0;
  bit bits [MAXBITS];
  int nbits, ndone, tcount;
  int t_cs_rise, t_first_rise, t_last_rise, t_last_fall, t_cs_fall;
  bit period_bad, done_aligned;
  logic sclk_q = 1'b0, cs_q = 1'b0;
  logic [7:0] exp_b [128];
  int exp_n;

  always #2 clk = ~clk;

  mlcd_line_tx #(.WIDTH_PX(W), .HEIGHT(H), .HALF_DIV(HD), .CS_SETUP(CSS), .CS_HOLD(CSH)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_row_first(cmd_row_first), .cmd_row_last(cmd_row_last), .vcom_pol(vcom_pol),
    .lb_rd_en(lb_rd_en), .lb_rd_addr(lb_rd_addr), .lb_rd_data(lb_rd_data),
    .sclk(sclk), .sdo(sdo), .cs(cs), .busy(busy), .done(done)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 53 + 17) ^ (a << 2));
  endfunction

  always @(posedge clk) if (lb_rd_en) lb_rd_data <= pat(int'(lb_rd_addr));

  always @(negedge clk) begin
    tcount <= tcount + 1;
    if (cs && !cs_q) t_cs_rise <= tcount;
    if (sclk && !sclk_q) begin
      if (nbits < MAXBITS) bits[nbits] <= sdo;
      if (nbits == 0) t_first_rise <= tcount;
      else if (tcount - t_last_rise != 2 * HD) period_bad <= 1'b1;
      t_last_rise <= tcount;
      nbits <= nbits + 1;
    end
    if (!sclk && sclk_q) t_last_fall <= tcount;
    if (!cs && cs_q) t_cs_fall <= tcount;
    if (done) begin
      ndone <= ndone + 1;
      if (!cs && cs_q) done_aligned <= 1'b1;
    end
    sclk_q <= sclk;
    cs_q   <= cs;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk);
    nbits = 0; ndone = 0; period_bad = 0; done_aligned = 0;
  endtask

  task automatic issue(input logic [1:0] op, input int f, input int l, input logic v);
    @(negedge clk);
    cmd_op = op; cmd_row_first = ROW_W'(f); cmd_row_last = ROW_W'(l); vcom_pol = v;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy === 1'b1, "R8", "busy after accept", int'(busy), 1);
  endtask

  task automatic wait_done();
    int guard = 0;
    while (ndone == 0 && guard < 20000) begin @(negedge clk); guard++; end
    chk(guard < 20000, "R9", "done seen before timeout", guard, 0);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [7:0] mode_exp(input logic [1:0] op, input logic v);
    logic [7:0] b = (op == 2'd1) ? 8'h01 : (op == 2'd2) ? 8'h04 : 8'h00;
    return b | (v ? 8'h02 : 8'h00);
  endfunction

  task automatic build_short(input logic [1:0] op, input logic v);
    exp_b[0] = mode_exp(op, v); exp_b[1] = 8'h00; exp_n = 2;
  endtask

  task automatic build_rows(input int f, input int l, input logic v);
    int fc = (f > H - 1) ? H - 1 : f;
    int lc = (l > H - 1) ? H - 1 : l;
    if (lc < fc) lc = fc;
    exp_n = 0;
    exp_b[exp_n++] = mode_exp(2'd1, v);
    for (int r = fc; r <= lc; r++) begin
      exp_b[exp_n++] = 8'(r + 1);
      for (int k = 0; k < BPR; k++) exp_b[exp_n++] = pat(r * BPR + k);
      exp_b[exp_n++] = 8'h00;
    end
  endtask

  task automatic check_frame(input string req);
    int bad = -1;
    logic [7:0] got = 0;
    chk(nbits == 8 * exp_n, req, "frame bit count", nbits, 8 * exp_n);
    for (int i = 0; i < exp_n && bad < 0; i++) begin
      logic [7:0] b;
      for (int j = 0; j < 8; j++) b[j] = bits[8 * i + j];
      if (b !== exp_b[i]) begin bad = i; got = b; end
    end
    if (bad >= 0) chk(1'b0, req, $sformatf("byte %0d (LSB first)", bad), int'(got), int'(exp_b[bad]));
    else chk(1'b1, req, "frame bytes", 0, 0);
    chk(ndone == 1, "R9", "done pulses per frame", ndone, 1);
    chk(done_aligned, "R9", "done with cs fall", int'(done_aligned), 1);
  endtask

  task automatic check_timing();
    chk(t_first_rise - t_cs_rise >= 2 * HD * CSS, "R7", "cs setup cycles", t_first_rise - t_cs_rise, 2 * HD * CSS);
    chk(t_cs_fall - t_last_fall >= 2 * HD * CSH, "R7", "cs hold cycles", t_cs_fall - t_last_fall, 2 * HD * CSH);
    chk(!period_bad, "R11", "sclk period", int'(period_bad), 0);
  endtask

  task automatic t_reset();
    chk({cs, sclk, sdo, busy, done, lb_rd_en} === 6'b0, "R10", "outputs after reset",
        int'({cs, sclk, sdo, busy, done, lb_rd_en}), 0);
  endtask

  task automatic t_short(input logic [1:0] op, input logic v, input string req);
    clear_mon(); build_short(op, v);
    issue(op, 0, 0, v); wait_done();
    check_frame(req); check_timing();
  endtask

  task automatic t_rows(input int f, input int l, input logic v, input string req);
    clear_mon(); build_rows(f, l, v);
    issue(2'd1, f, l, v); wait_done();
    check_frame(req); check_timing();
  endtask

  task automatic t_ignore();
    int held;
    clear_mon(); build_rows(0, 1, 1'b0);
    issue(2'd1, 0, 1, 1'b0);
    repeat (50) @(negedge clk);
    cmd_op = 2'd2; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
    wait_done();
    check_frame("R8");
    held = nbits;
    repeat (40) @(negedge clk);
    chk(nbits == held && !cs && !busy, "R8", "no frame from ignored request", nbits, held);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tcount = 0; nbits = 0; ndone = 0;
    t_cs_rise = 0; t_first_rise = 0; t_last_rise = 0; t_last_fall = 0; t_cs_fall = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();                        // R10
    t_short(2'd0, 1'b0, "R3");        // keep-alive, R1 R2 R3
    t_short(2'd0, 1'b1, "R1");        // polarity in bit 1
    t_short(2'd2, 1'b1, "R1");        // blank 0x06
    t_short(2'd3, 1'b0, "R3");        // alternate keep-alive code
    t_rows(0, 0, 1'b0, "R4");         // single row, R6 data path
    t_rows(3, 5, 1'b1, "R4");         // three rows, address bytes 4..6
    t_rows(11, 11, 1'b0, "R5");       // last row, address 12
    t_rows(9, 15, 1'b0, "R5");        // clamp of last row
    t_rows(5, 2, 1'b1, "R5");         // reversed range sends first only
    t_rows(0, 11, 1'b0, "R2");        // full panel
    t_ignore();                       // R8
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule